// File: doc/BRIEF.md
# Serial link loopback and output-enable controller

This block sits between a parallel user interface and a one-bit serial line. It turns a parallel transmit word into a serial frame and turns a serial stream back into a parallel receive word. The frame carries a leading 1 marker, then the data bits with the least significant bit first, then a trailing 0 marker. One bit moves per clock. The receiver finds frame alignment from the markers, declares lock, and drops lock after repeated marker errors. Around this pair the block routes data for two test loopbacks. In the first, the received stream is retransmitted through the receiver and then the transmitter. In the second, transmit data goes through the whole transmitter and receiver chain and back to the parallel output.

Each output group has its own active-high enable output that a pad ring can map to a tri-state driver. An active-low transmit enable input and an active-low receive enable input drive these. The loopback selects are sampled only at a frame boundary.

The receiver is a state machine with five states. SEEK_LOW waits for a 0 bit and then moves to SEEK_HIGH. SEEK_HIGH waits for a 1 bit, treats it as a start marker, and moves to TAKE_DATA. TAKE_DATA shifts in DATA_W bits and then moves to CHECK_STOP. CHECK_STOP has three exits:
- A good frame goes to EXPECT_START.
- While locked, a bad frame that is below the miss limit also goes to EXPECT_START.
- Any other case goes to SEEK_LOW.

EXPECT_START takes one bit, records whether it was a proper start marker, and moves to TAKE_DATA. The transmit side is a frame counter whose wrap is the frame boundary. A mode register is loaded at that boundary with one of three values: MODE_NORMAL, MODE_LINE or MODE_LOCAL.

Top module: `serdes_loopback_ctrl`

## Requirements
- R1: The transmit stream is a continuous sequence of DATA_W+2 bit frames, one bit per clock. Each frame is a 1 start bit, then the data word least significant bit first, then a 0 stop bit.
- R2: After reset the receive side is unlocked and rx_valid, rx_word and rx_strobe are 0. The first frame that begins after a 0-to-1 transition and ends in a 0 stop bit locks the receiver. A frame whose stop bit is 1 does not lock it.
- R3: While locked, a single bad frame keeps the lock and does not deliver its word. MISS_LIMIT (2) bad frames in a row drop the lock, and the next frame that qualifies under R2 regains it.
- R4: On the clock after the stop bit of a good frame arrives, rx_word shows that frame's word and rx_strobe is high for exactly one cycle.
- R5: In line loopback (line_lb=1, local_lb=0), the receiver takes ser_in and the word it receives appears on rx_word. The transmitter sends the most recently received word instead of tx_word.
- R6: In local loopback (local_lb=1), the transmitter sends tx_word and the receiver takes the transmitter's own bit stream, so tx_word returns on rx_word. ser_oe is 0 and ser_out is 0 in this mode.
- R7: When both loopback selects are 1, local loopback is used.
- R8: The loopback selects are sampled only on the clock at which a new frame is loaded. A change in mid-frame takes effect at the next frame.
- R9: While tx_en_n is 1, ser_oe and ser_out are 0. The transmitter keeps running, so when tx_en_n returns to 0 the output resumes the current frame sequence.
- R10: While rx_en_n is 1, rx_valid, rx_word and rx_strobe are 0. Lock and the held word are kept, so when rx_en_n returns to 0 the previous word and valid state reappear at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_word | input | DATA_W | Parallel word to transmit |
| ser_in | input | 1 | Serial receive bit |
| line_lb | input | 1 | Line loopback select |
| local_lb | input | 1 | Local loopback select, wins over line_lb |
| tx_en_n | input | 1 | Active-low transmit output enable |
| rx_en_n | input | 1 | Active-low receive output enable |
| ser_out | output | 1 | Serial transmit bit, 0 when disabled |
| ser_oe | output | 1 | Enable for the serial output driver |
| rx_word | output | DATA_W | Last good received word, 0 when disabled |
| rx_strobe | output | 1 | One-cycle strobe for each new received word |
| rx_valid | output | 1 | Receive outputs enabled and receiver locked |

## Verification
The transmit stream is checked against a per-clock model in normal mode with several changing words, and in line loopback with a repeated received word. This shows whether the transmitter takes its data from tx_word or from the receiver. Serial input frames are sent with good markers, with a bad stop marker while unlocked, with one bad frame while locked, and with two bad frames in a row. These separate locking, tolerating a miss and losing lock. Local loopback is tried with both selects high and a word with a single 0-to-1 transition. Only correct alignment can lock on that word, so a returned word also shows that the internal path and the priority work. The enable tests toggle each enable between frames and in mid-frame, which shows that the output resumes instead of restarting.

// File: rtl/serdes_lb_pkg.sv
package serdes_lb_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_LINE   = 2'd1,
        MODE_LOCAL  = 2'd2
    } lb_mode_t;

    typedef enum logic [2:0] {
        SEEK_LOW     = 3'd0,
        SEEK_HIGH    = 3'd1,
        TAKE_DATA    = 3'd2,
        CHECK_STOP   = 3'd3,
        EXPECT_START = 3'd4
    } rx_state_t;

endpackage

// File: rtl/slb_serializer.sv
module slb_serializer #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] load_word,
    output logic              frame_start,
    output logic              bit_out
);
    localparam int FRAME_LEN = DATA_W + 2;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0]     pos_q;
    logic [FRAME_LEN-1:0] shreg_q;

    assign frame_start = (pos_q == LAST);
    assign bit_out     = shreg_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= LAST;
            shreg_q <= '0;
        end else if (frame_start) begin
            pos_q   <= '0;
            shreg_q <= {1'b0, load_word, 1'b1};
        end else begin
            pos_q   <= pos_q + 1'b1;
            shreg_q <= {1'b0, shreg_q[FRAME_LEN-1:1]};
        end
    end
endmodule

// File: rtl/slb_deserializer.sv
module slb_deserializer
    import serdes_lb_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int MISS_LIMIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_stb,
    output logic              locked
);
    localparam int CNT_W  = $clog2(DATA_W);
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(DATA_W - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    rx_state_t          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [DATA_W-1:0]  sh_q;
    logic [MISS_W-1:0]  miss_q;
    logic               start_bad_q;
    logic               good_frame;

    assign good_frame = !bit_in && !start_bad_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEEK_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEEK_LOW:     if (!bit_in) state_d = SEEK_HIGH;
            SEEK_HIGH:    if (bit_in)  state_d = TAKE_DATA;
            TAKE_DATA:    if (cnt_q == LAST_BIT) state_d = CHECK_STOP;
            CHECK_STOP: begin
                if (good_frame)                        state_d = EXPECT_START;
                else if (locked && miss_q != MISS_LAST) state_d = EXPECT_START;
                else                                   state_d = SEEK_LOW;
            end
            EXPECT_START: state_d = TAKE_DATA;
            default:      state_d = SEEK_LOW;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            sh_q        <= '0;
            miss_q      <= '0;
            start_bad_q <= 1'b0;
            word_out    <= '0;
            word_stb    <= 1'b0;
            locked      <= 1'b0;
        end else begin
            word_stb <= 1'b0;
            unique case (state_q)
                SEEK_LOW: ;
                SEEK_HIGH: begin
                    cnt_q       <= '0;
                    start_bad_q <= 1'b0;
                end
                TAKE_DATA: begin
                    sh_q  <= {bit_in, sh_q[DATA_W-1:1]};
                    cnt_q <= cnt_q + 1'b1;
                end
                CHECK_STOP: begin
                    if (good_frame) begin
                        word_out <= sh_q;
                        word_stb <= 1'b1;
                        locked   <= 1'b1;
                        miss_q   <= '0;
                    end else if (locked) begin
                        if (miss_q == MISS_LAST) begin
                            locked <= 1'b0;
                            miss_q <= '0;
                        end else begin
                            miss_q <= miss_q + 1'b1;
                        end
                    end
                end
                EXPECT_START: begin
                    start_bad_q <= !bit_in;
                    cnt_q       <= '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/serdes_loopback_ctrl.sv
module serdes_loopback_ctrl
    import serdes_lb_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int MISS_LIMIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              ser_in,
    input  logic              line_lb,
    input  logic              local_lb,
    input  logic              tx_en_n,
    input  logic              rx_en_n,
    output logic              ser_out,
    output logic              ser_oe,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_strobe,
    output logic              rx_valid
);
    lb_mode_t          mode_q, mode_d;
    logic              frame_start;
    logic              ser_bit;
    logic              des_in;
    logic [DATA_W-1:0] load_word;
    logic [DATA_W-1:0] rx_hold;
    logic              rx_stb;
    logic              rx_locked;
    logic              tx_on, rx_on;

    // local select wins over line select
    always_comb begin
        if (local_lb)     mode_d = MODE_LOCAL;
        else if (line_lb) mode_d = MODE_LINE;
        else              mode_d = MODE_NORMAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           mode_q <= MODE_NORMAL;
        else if (frame_start) mode_q <= mode_d;
    end

    assign load_word = (mode_d == MODE_LINE) ? rx_hold : tx_word;
    assign des_in    = (mode_q == MODE_LOCAL) ? ser_bit : ser_in;

    slb_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_word   (load_word),
        .frame_start (frame_start),
        .bit_out     (ser_bit)
    );

    slb_deserializer #(.DATA_W(DATA_W), .MISS_LIMIT(MISS_LIMIT)) u_des (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (des_in),
        .word_out (rx_hold),
        .word_stb (rx_stb),
        .locked   (rx_locked)
    );

    assign tx_on     = !tx_en_n && (mode_q != MODE_LOCAL);
    assign rx_on     = !rx_en_n && rx_locked;
    assign ser_oe    = tx_on;
    assign ser_out   = ser_bit & tx_on;
    assign rx_valid  = rx_on;
    assign rx_word   = rx_on ? rx_hold : '0;
    assign rx_strobe = rx_stb & rx_on;
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              local_lb,
    input logic              tx_en_n,
    input logic              rx_en_n,
    input logic              ser_out,
    input logic              ser_oe,
    input logic [DATA_W-1:0] rx_word,
    input logic              rx_strobe,
    input logic              rx_valid,
    input logic              frame_start,
    input logic [1:0]        mode
);
    // R9
    tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_n |-> (!ser_oe && !ser_out));

    // R10
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_n |-> (!rx_valid && rx_word == '0 && !rx_strobe));

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    // R2
    strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> rx_valid);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(mode));

    // R7
    local_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && local_lb) |=> (mode == 2'd2));

    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out |-> ser_oe);
endmodule

bind serdes_loopback_ctrl slb_checker #(.DATA_W(DATA_W)) u_slb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .local_lb    (local_lb),
    .tx_en_n     (tx_en_n),
    .rx_en_n     (rx_en_n),
    .ser_out     (ser_out),
    .ser_oe      (ser_oe),
    .rx_word     (rx_word),
    .rx_strobe   (rx_strobe),
    .rx_valid    (rx_valid),
    .frame_start (frame_start),
    .mode        (mode_q)
);

// File: tb/test_serdes_loopback_ctrl.sv
module test_serdes_loopback_ctrl;
    localparam int W     = 16;
    localparam int FRAME = W + 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] tx_word = 16'h1234;
    logic         ser_in = 1'b0;
    logic         line_lb = 1'b0;
    logic         local_lb = 1'b0;
    logic         tx_en_n = 1'b0;
    logic         rx_en_n = 1'b0;
    logic         ser_out, ser_oe, rx_strobe, rx_valid;
    logic [W-1:0] rx_word;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // line-mode data expectation, supplied by the sequence below
    logic [W-1:0] exp_line = '0;
    bit           line_ok  = 0;

    always #10 clk = ~clk;

    serdes_loopback_ctrl #(.DATA_W(W)) i_serdes_loopback_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .ser_in(ser_in),
        .line_lb(line_lb), .local_lb(local_lb), .tx_en_n(tx_en_n),
        .rx_en_n(rx_en_n), .ser_out(ser_out), .ser_oe(ser_oe),
        .rx_word(rx_word), .rx_strobe(rx_strobe), .rx_valid(rx_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // transmit-side reference model, compared every clock
    int           m_pos = FRAME - 1;
    logic [FRAME-1:0] m_frame = '0;
    bit           m_local = 0;
    bit           m_chk = 1;
    always begin
        @(posedge clk);
        if (!rst_n) begin
            m_pos = FRAME - 1; m_local = 0; m_frame = '0; m_chk = 1;
        end else if (m_pos == FRAME - 1) begin
            bit is_line;
            logic [W-1:0] d;
            m_local = local_lb;
            is_line = line_lb && !local_lb;
            d = is_line ? exp_line : tx_word;
            m_frame = {1'b0, d, 1'b1};
            m_chk = !is_line || line_ok;
            m_pos = 0;
        end else begin
            m_pos++;
        end
        #2;
        if (rst_n) begin
            bit eoe;
            eoe = !tx_en_n && !m_local;
            chk("R6 R9 ser_oe", 32'(ser_oe), 32'(eoe));
            if (m_chk) chk("R1 R5 ser_out", 32'(ser_out), 32'(m_frame[m_pos] & eoe));
        end
    end

    task automatic drive_bit(input logic b);
        @(negedge clk);
        ser_in = b;
    endtask

    task automatic send_frame(input logic [W-1:0] w, input logic stop);
        drive_bit(1'b1);
        for (int i = 0; i < W; i++) drive_bit(w[i]);
        drive_bit(stop);
    endtask

    task automatic after_edge();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog: actual timeout expected completion");
        errors++;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        after_edge();
        // R2 reset state
        chk("R2 reset rx_valid", 32'(rx_valid), 0);
        chk("R2 reset rx_word", 32'(rx_word), 0);
        chk("R2 reset rx_strobe", 32'(rx_strobe), 0);

        // R2 bad stop while unlocked: no lock
        send_frame(16'hA5C3, 1'b1);
        after_edge();
        chk("R2 no lock on bad stop", 32'(rx_valid), 0);
        drive_bit(1'b0);
        tx_word = 16'h8E71;

        // R2 R4 first good frame locks and strobes
        send_frame(16'hA5C3, 1'b0);
        after_edge();
        chk("R2 lock rx_valid", 32'(rx_valid), 1);
        chk("R4 strobe", 32'(rx_strobe), 1);
        chk("R4 word", 32'(rx_word), 32'h0000A5C3);

        // R3 single bad frame keeps lock, word not delivered
        send_frame(16'h0F0F, 1'b1);
        after_edge();
        chk("R3 lock kept", 32'(rx_valid), 1);
        chk("R3 word kept", 32'(rx_word), 32'h0000A5C3);
        chk("R3 no strobe", 32'(rx_strobe), 0);

        // R3 second bad frame drops lock
        send_frame(16'h0F0F, 1'b1);
        after_edge();
        chk("R3 lock lost", 32'(rx_valid), 0);
        drive_bit(1'b0);
        tx_word = 16'h0001;

        // R3 relock
        send_frame(16'h3C3C, 1'b0);
        after_edge();
        chk("R3 relock", 32'(rx_valid), 1);
        chk("R3 relock word", 32'(rx_word), 32'h00003C3C);

        // R5 line loopback
        line_lb = 1'b1;
        for (int i = 0; i < 3; i++) send_frame(16'h5A69, 1'b0);
        after_edge();
        chk("R5 rx word in line mode", 32'(rx_word), 32'h00005A69);
        exp_line = 16'h5A69;
        line_ok = 1;
        for (int i = 0; i < 4; i++) send_frame(16'h5A69, 1'b0);

        // R10 receive disable and resume
        rx_en_n = 1'b1;
        send_frame(16'h5A69, 1'b0);
        after_edge();
        chk("R10 rx_valid off", 32'(rx_valid), 0);
        chk("R10 rx_word off", 32'(rx_word), 0);
        chk("R10 rx_strobe off", 32'(rx_strobe), 0);
        rx_en_n = 1'b0;
        after_edge();
        chk("R10 rx_valid back", 32'(rx_valid), 1);
        chk("R10 rx_word back", 32'(rx_word), 32'h00005A69);

        // R9 transmit disable across frames and resume in mid-frame
        send_frame(16'h5A69, 1'b0);
        tx_en_n = 1'b1;
        send_frame(16'h5A69, 1'b0);
        send_frame(16'h5A69, 1'b0);
        for (int i = 0; i < 7; i++) drive_bit(1'b1);
        tx_en_n = 1'b0;
        for (int i = 0; i < 9; i++) drive_bit(1'b0);
        drive_bit(1'b0);
        send_frame(16'h5A69, 1'b0);

        // R6 R7 R8 local loopback with both selects, changed in mid-frame
        ser_in = 1'b0;
        tx_word = 16'h00FF;
        repeat (5) @(negedge clk);
        local_lb = 1'b1;
        repeat (8 * FRAME) @(negedge clk);
        begin
            bit seen = 0;
            for (int i = 0; i < 4 * FRAME; i++) begin
                after_edge();
                if (rx_strobe) begin seen = 1; break; end
            end
            chk("R6 R7 local strobe seen", 32'(seen), 1);
            chk("R6 R7 local word", 32'(rx_word), 32'h000000FF);
            chk("R6 local valid", 32'(rx_valid), 1);
            chk("R6 ser_oe off", 32'(ser_oe), 0);
        end

        // R8 leave local mode in mid-frame, back to normal
        repeat (3) @(negedge clk);
        local_lb = 1'b0;
        line_lb = 1'b0;
        tx_word = 16'hBEEF;
        repeat (3 * FRAME) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule